// File: doc/BRIEF.md
# Pass-Through Cycle Responder

This block sits on the add-on side of a host-bus bridge. It services the single accesses and bursts that the bridge forwards. The bridge drives an active-low attention line to show that a host cycle is waiting. While attention is low, the bridge also presents a 2-bit window number, four active-low byte enables, a direction flag and an active-low burst flag. The address does not come with the cycle. The responder must ask for it with a one-clock, active-low address strobe, during which it drives no other control. The bridge answers by placing the address on the shared data input.

Each of the four windows owns a private bank of sixteen 32-bit words. Bits [5:2] of the fetched address select the word. On a write, only the byte lanes whose enables are low are updated. On a read, the stored word is driven out during the ready cycle. Every access ends with a one-clock, active-low ready pulse. If the bridge holds both attention and burst low through that ready cycle, another beat follows. That beat reuses the fetched address, advanced by one word with wrap-around inside the 16-word bank, and no new strobe is issued.

Top module: `pt_responder`

## Requirements
- R1: While reset is high, and on the first cycle after it, `addr_strobe_n` and `rdy_n` are 1 and `dq_oe` is 0.
- R2: When `attn_n` is low in the idle state, `addr_strobe_n` goes low on the next cycle for exactly one clock. During that clock `rdy_n` is 1 and `dq_oe` is 0. While `attn_n` stays high, no strobe is issued.
- R3: The address is taken from `dq_in` during the strobe cycle. Only bits [5:2] select the word; all other address bits are ignored.
- R4: `win_num` values 0, 1, 2 and 3 select four independent banks. A write in one window leaves the same word in the other windows unchanged.
- R5: On a write (`wr_dir`=1), byte lane k (bits 8k+7:8k) of the selected word is updated from `dq_in` only when `be_n[k]` is 0.
- R6: On a read (`wr_dir`=0), `dq_oe` is 1 for exactly the ready cycle. In that cycle, every enabled lane of `dq_out` equals the stored byte. When `dq_oe` is 0, `dq_out` is all zeros.
- R7: `rdy_n` is low for one clock. That clock is the second cycle after the strobe cycle, and two cycles after the ready cycle of the previous burst beat.
- R8: If `attn_n` and `burst_n` are both low in the ready cycle, the next beat proceeds without a strobe, addresses the following word, and takes its own byte enables and write data.
- R9: Otherwise the responder returns to idle, and the next attention starts a fresh address fetch.
- R10: The burst word index wraps from 15 to 0 within the same window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| attn_n | input | 1 | Active-low attention from the bridge |
| win_num | input | 2 | Window hit (0..3), valid while attention is low |
| wr_dir | input | 1 | 1 = write, 0 = read, valid while attention is low |
| burst_n | input | 1 | Active-low: more beats follow the current one |
| be_n | input | 4 | Active-low byte-lane enables |
| dq_in | input | 32 | Address during the strobe, write data otherwise |
| addr_strobe_n | output | 1 | Active-low request for the bridge to drive the address |
| rdy_n | output | 1 | Active-low one-clock completion pulse |
| dq_out | output | 32 | Read data, valid while dq_oe is 1 |
| dq_oe | output | 1 | Read data is being driven |

## Verification
The hardest behaviour to reach from the ports is a burst that crosses the end of a bank. Each beat must pick up new enables and data that the bridge changes only after the previous ready pulse. The stimulus starts a multi-beat burst at word 14, so the index wraps to 0 and 1. Bridge-side inputs are changed in the ready cycle, and the bench checks that no second strobe appears. Partial-lane writes and reads are also issued with address bits outside [5:2] set. This shows that those bits and the disabled lanes have no effect, seen through later full-word reads.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FETCH  = 2'd1,
    ST_ACCESS = 2'd2,
    ST_DONE   = 2'd3
  } pt_state_e;
endpackage

// File: rtl/pt_seq.sv
module pt_seq
  import pt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      attn_n,
  input  logic      burst_n,
  output pt_state_e state,
  output logic      start_cyc,
  output logic      advance,
  output logic      addr_strobe_n,
  output logic      rdy_n
);
  pt_state_e nxt;

  always_comb begin
    nxt       = state;
    start_cyc = 1'b0;
    advance   = 1'b0;
    case (state)
      ST_IDLE: if (!attn_n) begin
        nxt       = ST_FETCH;
        start_cyc = 1'b1;
      end
      ST_FETCH:  nxt = ST_ACCESS;
      ST_ACCESS: nxt = ST_DONE;
      ST_DONE: begin
        if (!attn_n && !burst_n) begin
          nxt     = ST_ACCESS;
          advance = 1'b1;
        end else begin
          nxt = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      addr_strobe_n <= 1'b1;
      rdy_n         <= 1'b1;
    end else begin
      state         <= nxt;
      addr_strobe_n <= (nxt != ST_FETCH);
      rdy_n         <= (nxt != ST_DONE);
    end
  end
endmodule

// File: rtl/pt_addr.sv
module pt_addr #(
  parameter int WIN_W = 2,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_cyc,
  input  logic             capture,
  input  logic             advance,
  input  logic [WIN_W-1:0] win_num,
  input  logic             wr_dir,
  input  logic [IDX_W-1:0] addr_bits,
  output logic             wr_q,
  output logic [WIN_W+IDX_W-1:0] bank_idx
);
  logic [WIN_W-1:0] win_q;
  logic [IDX_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '0;
      word_q <= '0;
      wr_q   <= 1'b0;
    end else begin
      if (start_cyc) begin
        win_q <= win_num;
        wr_q  <= wr_dir;
      end
      if (capture)
        word_q <= addr_bits;
      else if (advance)
        word_q <= word_q + 1'b1;
    end
  end

  assign bank_idx = {win_q, word_q};
endmodule

// File: rtl/pt_lane_ram.sv
module pt_lane_ram #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/pt_responder.sv
module pt_responder
  import pt_pkg::*;
#(
  parameter int DQ_W  = 32,
  parameter int N_WIN = 4,
  parameter int WORDS = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     attn_n,
  input  logic [$clog2(N_WIN)-1:0] win_num,
  input  logic                     wr_dir,
  input  logic                     burst_n,
  input  logic [DQ_W/8-1:0]        be_n,
  input  logic [DQ_W-1:0]          dq_in,
  output logic                     addr_strobe_n,
  output logic                     rdy_n,
  output logic [DQ_W-1:0]          dq_out,
  output logic                     dq_oe
);
  localparam int BE_W  = DQ_W / 8;
  localparam int WIN_W = $clog2(N_WIN);
  localparam int IDX_W = $clog2(WORDS);
  localparam int LSB   = $clog2(BE_W);
  localparam int AW    = WIN_W + IDX_W;

  pt_state_e      state;
  logic           start_cyc, advance, wr_q;
  logic [AW-1:0]  bank_idx;
  logic [DQ_W-1:0] rd_word;
  logic           access;

  pt_seq u_seq (
    .clk(clk), .rst(rst), .attn_n(attn_n), .burst_n(burst_n),
    .state(state), .start_cyc(start_cyc), .advance(advance),
    .addr_strobe_n(addr_strobe_n), .rdy_n(rdy_n)
  );

  pt_addr #(.WIN_W(WIN_W), .IDX_W(IDX_W)) u_addr (
    .clk(clk), .rst(rst), .start_cyc(start_cyc),
    .capture(state == ST_FETCH), .advance(advance),
    .win_num(win_num), .wr_dir(wr_dir),
    .addr_bits(dq_in[LSB +: IDX_W]),
    .wr_q(wr_q), .bank_idx(bank_idx)
  );

  assign access = (state == ST_ACCESS);

  for (genvar k = 0; k < BE_W; k++) begin : g_lane
    pt_lane_ram #(.AW(AW)) u_ram (
      .clk(clk),
      .we(access && wr_q && !be_n[k]),
      .addr(bank_idx),
      .wdata(dq_in[8*k +: 8]),
      .rdata(rd_word[8*k +: 8])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) dq_oe <= 1'b0;
    else     dq_oe <= access && !wr_q;
  end

  assign dq_out = dq_oe ? rd_word : '0;
endmodule

// File: rtl/pt_responder_chk.sv
module pt_responder_chk (
  input logic clk,
  input logic rst,
  input logic attn_n,
  input logic burst_n,
  input logic addr_strobe_n,
  input logic rdy_n,
  input logic dq_oe
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (addr_strobe_n && rdy_n && !dq_oe));

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    !addr_strobe_n |=> addr_strobe_n);

  // R2
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !addr_strobe_n |-> (rdy_n && !dq_oe));

  // R7
  rdy_single_chk: assert property (@(posedge clk) disable iff (rst)
    !rdy_n |=> rdy_n);

  // R7
  rdy_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !addr_strobe_n |=> ##1 !rdy_n);

  // R6
  oe_in_ready_chk: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> !rdy_n);

  // R8
  burst_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (!rdy_n && !attn_n && !burst_n) |=> (addr_strobe_n ##1 (!rdy_n && addr_strobe_n)));
endmodule

bind pt_responder pt_responder_chk u_chk (
  .clk(clk), .rst(rst), .attn_n(attn_n), .burst_n(burst_n),
  .addr_strobe_n(addr_strobe_n), .rdy_n(rdy_n), .dq_oe(dq_oe)
);

// File: tb/sim_pt_responder.sv
module sim_pt_responder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        attn_n = 1'b1;
  logic [1:0]  win_num = '0;
  logic        wr_dir = 1'b0;
  logic        burst_n = 1'b1;
  logic [3:0]  be_n = 4'hF;
  logic [31:0] dq_in;
  logic [31:0] cur_addr = '0;
  logic [31:0] wdata = '0;
  logic        addr_strobe_n, rdy_n, dq_oe;
  logic [31:0] dq_out;

  int checks = 0;
  int failures = 0;
  logic [31:0] ref_mem [4][16];

  always #10 clk = ~clk;

  // bridge model: address while strobed, write data otherwise
  assign dq_in = addr_strobe_n ? wdata : cur_addr;

  pt_responder u0 (
    .clk(clk), .rst(rst), .attn_n(attn_n), .win_num(win_num),
    .wr_dir(wr_dir), .burst_n(burst_n), .be_n(be_n), .dq_in(dq_in),
    .addr_strobe_n(addr_strobe_n), .rdy_n(rdy_n),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [31:0] lane_mask(input logic [3:0] ben);
    logic [31:0] m = '0;
    for (int k = 0; k < 4; k++) if (!ben[k]) m[8*k +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // one clock of the reference model: compare all control outputs
  task automatic cyc(input logic es, input logic er, input logic eo, input string req);
    @(negedge clk);
    check({req, " strobe"}, {31'd0, addr_strobe_n}, {31'd0, es});
    check({req, " ready"},  {31'd0, rdy_n},         {31'd0, er});
    check({req, " oe"},     {31'd0, dq_oe},         {31'd0, eo});
    if (!eo) check({req, " dq_out idle R6"}, dq_out, 32'd0);
  endtask

  task automatic txn(input int win, input logic [31:0] a, input bit wr, input int n,
                     input logic [3:0] ben, input logic [31:0] d0, input string req);
    int idx;
    logic [31:0] m;
    attn_n   = 1'b0;
    win_num  = win[1:0];
    wr_dir   = wr;
    be_n     = ben;
    burst_n  = (n > 1) ? 1'b0 : 1'b1;
    cur_addr = a;
    wdata    = d0;
    cyc(1'b0, 1'b1, 1'b0, {req, " fetch R2"});
    for (int b = 0; b < n; b++) begin
      idx = int'((a >> 2) + b) % 16;   // R10 wrap, R3 bits [5:2]
      cyc(1'b1, 1'b1, 1'b0, {req, " access R8"});
      cyc(1'b1, 1'b0, !wr, {req, " ready R7"});
      m = lane_mask(be_n);
      if (wr) begin
        ref_mem[win][idx] = (ref_mem[win][idx] & ~m) | (wdata & m);
      end else begin
        check({req, " read data R6"}, dq_out & m, ref_mem[win][idx] & m);
      end
      if (b < n - 1) begin
        wdata = d0 + 32'h0101_0101 * (b + 1);
        be_n  = ben;
      end else begin
        burst_n = 1'b1;
        attn_n  = 1'b1;
      end
    end
    cyc(1'b1, 1'b1, 1'b0, {req, " back to idle R9"});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (5) @(negedge clk);
    // R1: outputs idle during reset
    check("R1 strobe in reset", {31'd0, addr_strobe_n}, 32'd1);
    check("R1 ready in reset",  {31'd0, rdy_n}, 32'd1);
    check("R1 oe in reset",     {31'd0, dq_oe}, 32'd0);
    rst = 1'b0;
    cyc(1'b1, 1'b1, 1'b0, "R1 after reset");
    // R2: no attention, no strobe
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 1'b0, "R2 idle");

    // R4/R5: full-word writes, same word in each window
    for (int w = 0; w < 4; w++)
      txn(w, 32'h0000_000C, 1'b1, 1, 4'h0, 32'hA0B0_C0D0 + w, "R4 write");
    for (int w = 0; w < 4; w++)
      txn(w, 32'h0000_000C, 1'b0, 1, 4'h0, 32'h0, "R4 read");

    // R3: high address bits and bits [1:0] ignored
    txn(1, 32'hABCD_0017, 1'b1, 1, 4'h0, 32'h1234_5678, "R3 write");
    txn(1, 32'h0000_0014, 1'b0, 1, 4'h0, 32'h0, "R3 read");

    // R5: partial write, lanes 0 and 2 only, then full read
    txn(2, 32'h0000_0020, 1'b1, 1, 4'h0, 32'h1111_1111, "R5 prefill");
    txn(2, 32'h0000_0020, 1'b1, 1, 4'b1010, 32'hEEDD_CCBB, "R5 partial");
    txn(2, 32'h0000_0020, 1'b0, 1, 4'h0, 32'h0, "R5 readback");

    // R6: partial-lane read
    txn(2, 32'h0000_0020, 1'b0, 1, 4'b0110, 32'h0, "R6 partial read");

    // R8/R10: burst from word 14 wraps to 0,1
    txn(3, 32'h0000_0038, 1'b1, 4, 4'h0, 32'h5500_0001, "R10 burst write");
    txn(3, 32'h0000_0038, 1'b0, 4, 4'h0, 32'h0, "R10 burst read");
    txn(3, 32'h0000_0000, 1'b0, 1, 4'h0, 32'h0, "R10 wrapped word");

    // R8: burst with partial lanes then read back
    txn(0, 32'h0000_0000, 1'b1, 3, 4'h0, 32'h0F0F_0F0F, "R8 burst prefill");
    txn(0, 32'h0000_0000, 1'b1, 3, 4'b1100, 32'h7766_5544, "R8 burst partial");
    txn(0, 32'h0000_0000, 1'b0, 3, 4'h0, 32'h0, "R8 burst read");

    // R4: window 0 word 3 untouched by other windows
    txn(0, 32'h0000_000C, 1'b0, 1, 4'h0, 32'h0, "R4 isolation");

    // R9: back-to-back cycles each fetch again
    txn(1, 32'h0000_0014, 1'b0, 1, 4'h0, 32'h0, "R9 again");
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b0, "R2 idle end");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule